// File: doc/BRIEF.md
# Three-Lane 7:1 Parallel Serializer

This block takes a 21-bit parallel word once per word-clock period and spreads it over three serial data lanes, each carrying seven bits per period. A fourth lane carries a fixed seven-slot clock pattern in step with the data, so a receiver can recover both the word clock and the word boundary. The fast bit clock is an input running at seven times the word clock, with a fixed phase to it. The outputs are single-ended logic models of differential lanes. Each output has its own output-enable, and an enable of 0 stands for high impedance.

The parallel word is captured on the word clock, on the rising or the falling edge as selected by `edge_sel`. It then passes through two registers into the bit-clock domain and is loaded into the lane shifters only at a frame boundary. An active-low power-down input releases every output. A `din_float` input marks the parallel inputs as undriven, and the data lanes then drive low. When the word clock stops, the forwarded clock lane keeps running on the bit clock.

Top module: `lane_serializer`

## Requirements
- R1: While `rst_n` is low, every output-enable (`lane_oe`, `fclk_oe`) is 0.
- R2: In slot s (s = 0..6, sent in increasing order) of a frame, `lane_q[k]` carries bit 7*k+s of the word captured for that frame.
- R3: In slots 0..6 of every frame, `fclk_q` carries 1,1,0,0,0,1,1. Its 0-to-1 transition falls between slots 4 and 5, so slot 0 of the next frame begins two bit periods after that transition.
- R4: With `edge_sel` = 0, the word serialized is the value `din` held at a rising edge of `word_clk`.
- R5: With `edge_sel` = 1, the word serialized is the value `din` held at a falling edge of `word_clk`.
- R6: One bit clock after `pwr_n` is sampled low, all four output-enables are 0. One bit clock after `pwr_n` is sampled high, they are all 1 again and serialization resumes with the current word.
- R7: While `pwr_n` is high and `din_float` is 1, the three data lanes drive 0 with their enables at 1, and the clock lane keeps its pattern.
- R8: If `word_clk` stops at a steady level, `fclk_q` keeps rising every 7 bit clocks. The data lanes keep repeating the last captured word, and later changes of `din` have no effect until `word_clk` runs again.
- R9: A frame never mixes bits of two captured words, even when `din` changes at arbitrary times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock, 7 times the word clock |
| word_clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_n | input | 1 | Active-low power-down |
| edge_sel | input | 1 | Capture edge: 0 rising, 1 falling |
| din_float | input | 1 | 1 marks the parallel inputs as undriven |
| din | input | 21 | Parallel input word |
| lane_q | output | 3 | Serial data lane values |
| lane_oe | output | 3 | Per-lane output-enable, 0 means high impedance |
| fclk_q | output | 1 | Forwarded clock lane value |
| fclk_oe | output | 1 | Forwarded clock lane output-enable |

## Verification
A wrong slot counter or a realignment fault shows at the ports within one frame: the forwarded clock loses its 1100011 shape or its seven-bit rising period, and the bench decodes each frame from that marker. Wrong lane mapping or a load in the middle of a frame gives a decoded word that matches no applied input, which shows up in the first frame after the fault. Wrong handling of the capture edge or the output mode shows either in the next frame or, for the enables, one bit clock after the input changes.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int DEF_LANES = 3;
  localparam int DEF_RATIO = 7;

  typedef enum logic [1:0] {
    DRV_OFF  = 2'd0,
    DRV_LOW  = 2'd1,
    DRV_DATA = 2'd2
  } drive_e;

  function automatic drive_e lane_mode(input logic pwr_n, input logic floating,
                                       input logic is_clk);
    if (!pwr_n)                 return DRV_OFF;
    else if (floating && !is_clk) return DRV_LOW;
    else                        return DRV_DATA;
  endfunction
endpackage

// File: rtl/ser_rst_sync.sv
module ser_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ser_word_capture.sv
module ser_word_capture #(
  parameter int WORD_W = 21
) (
  input  logic              word_clk,
  input  logic              rst_n,
  input  logic              edge_sel,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] rise_q, fall_q;

  always_ff @(posedge word_clk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= din;
  end

  always_ff @(negedge word_clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= din;
  end

  assign word = edge_sel ? fall_q : rise_q;
endmodule

// File: rtl/ser_timing.sv
module ser_timing #(
  parameter int RATIO      = 7,
  parameter int WORD_W     = 21,
  parameter int ALIGN_SLOT = 1,
  localparam int SW        = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              word_clk,
  input  logic [WORD_W-1:0] word_in,
  output logic [SW-1:0]     slot,
  output logic              load,
  output logic [WORD_W-1:0] word_out
);
  localparam logic [SW-1:0] LAST  = SW'(RATIO - 1);
  localparam logic [SW-1:0] ALIGN = SW'(ALIGN_SLOT);

  logic [2:0]        wsync_q, wsync_d;
  logic [SW-1:0]     cnt_q, cnt_d;
  logic [WORD_W-1:0] w1_q, w2_q;
  logic              word_rise;

  always_comb begin
    wsync_d   = {wsync_q[1:0], word_clk};
    word_rise = wsync_q[1] & ~wsync_q[2];
    if (word_rise)          cnt_d = ALIGN;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      wsync_q <= '0;
      cnt_q   <= '0;
      w1_q    <= '0;
      w2_q    <= '0;
    end else begin
      wsync_q <= wsync_d;
      cnt_q   <= cnt_d;
      w1_q    <= word_in;
      w2_q    <= w1_q;
    end
  end

  assign slot     = cnt_q;
  assign load     = (cnt_q == LAST);
  assign word_out = w2_q;
endmodule

// File: rtl/ser_lane_driver.sv
module ser_lane_driver
  import ser_pkg::*;
#(
  parameter int RATIO = 7,
  localparam int SW   = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic             bit_clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SW-1:0]    slot,
  input  logic [RATIO-1:0] bits,
  input  drive_e           mode,
  output logic             q,
  output logic             oe
);
  logic [RATIO-1:0] frame_q, frame_d;
  logic             q_d, oe_d;

  always_comb begin
    frame_d = load ? bits : frame_q;
    case (mode)
      DRV_DATA: begin q_d = frame_q[slot]; oe_d = 1'b1; end
      DRV_LOW:  begin q_d = 1'b0;          oe_d = 1'b1; end
      default:  begin q_d = 1'b0;          oe_d = 1'b0; end
    endcase
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      q       <= 1'b0;
      oe      <= 1'b0;
    end else begin
      frame_q <= frame_d;
      q       <= q_d;
      oe      <= oe_d;
    end
  end
endmodule

// File: rtl/lane_serializer.sv
module lane_serializer
  import ser_pkg::*;
#(
  parameter int               LANES       = DEF_LANES,
  parameter int               RATIO       = DEF_RATIO,
  parameter logic [RATIO-1:0] CLK_PATTERN = 7'b1100011,
  parameter int               ALIGN_SLOT  = 1,
  localparam int              WORD_W      = LANES * RATIO,
  localparam int              SW          = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic              bit_clk,
  input  logic              word_clk,
  input  logic              rst_n,
  input  logic              pwr_n,
  input  logic              edge_sel,
  input  logic              din_float,
  input  logic [WORD_W-1:0] din,
  output logic [LANES-1:0]  lane_q,
  output logic [LANES-1:0]  lane_oe,
  output logic              fclk_q,
  output logic              fclk_oe
);
  logic              rst_bit_n, rst_word_n;
  logic [WORD_W-1:0] word_cap, word_bit;
  logic [SW-1:0]     slot;
  logic              load;
  logic [LANES:0]    drv_q, drv_oe;

  ser_rst_sync u_rst_bit  (.clk(bit_clk),  .rst_n(rst_n), .rst_sync_n(rst_bit_n));
  ser_rst_sync u_rst_word (.clk(word_clk), .rst_n(rst_n), .rst_sync_n(rst_word_n));

  ser_word_capture #(.WORD_W(WORD_W)) u_cap (
    .word_clk (word_clk),
    .rst_n    (rst_word_n),
    .edge_sel (edge_sel),
    .din      (din),
    .word     (word_cap)
  );

  ser_timing #(.RATIO(RATIO), .WORD_W(WORD_W), .ALIGN_SLOT(ALIGN_SLOT)) u_tim (
    .bit_clk  (bit_clk),
    .rst_n    (rst_bit_n),
    .word_clk (word_clk),
    .word_in  (word_cap),
    .slot     (slot),
    .load     (load),
    .word_out (word_bit)
  );

  for (genvar k = 0; k <= LANES; k++) begin : g_lane
    localparam bit IS_CLK = (k == LANES);
    logic [RATIO-1:0] bits;
    drive_e           mode;
    if (IS_CLK) begin : g_clk
      assign bits = CLK_PATTERN;
    end else begin : g_data
      assign bits = word_bit[k*RATIO +: RATIO];
    end
    assign mode = lane_mode(pwr_n, din_float, IS_CLK);

    ser_lane_driver #(.RATIO(RATIO)) u_drv (
      .bit_clk (bit_clk),
      .rst_n   (rst_bit_n),
      .load    (load),
      .slot    (slot),
      .bits    (bits),
      .mode    (mode),
      .q       (drv_q[k]),
      .oe      (drv_oe[k])
    );
  end

  assign lane_q  = drv_q[LANES-1:0];
  assign lane_oe = drv_oe[LANES-1:0];
  assign fclk_q  = drv_q[LANES];
  assign fclk_oe = drv_oe[LANES];
endmodule

// File: rtl/ser_checker.sv
module ser_checker #(
  parameter int LANES = 3,
  parameter int RATIO = 7
) (
  input logic             bit_clk,
  input logic             rst_n,
  input logic             pwr_n,
  input logic             din_float,
  input logic [LANES-1:0] lane_q,
  input logic [LANES-1:0] lane_oe,
  input logic             fclk_q,
  input logic             fclk_oe
);
  logic        prev_q;
  logic [7:0]  gap_q;
  logic [2:0]  armed_q;
  logic        rise;

  assign rise = fclk_q & ~prev_q;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      gap_q   <= '0;
      armed_q <= '0;
    end else begin
      prev_q <= fclk_q;
      if (!fclk_oe) begin
        armed_q <= '0;
        gap_q   <= '0;
      end else if (rise) begin
        gap_q <= '0;
        if (armed_q != 3'd4) armed_q <= armed_q + 1'b1;
      end else if (gap_q != 8'hff) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  AST_PWRDN_OFF: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !pwr_n |=> (lane_oe == '0 && !fclk_oe)); // R6
  AST_PWRDN_RELEASE: assert property (@(posedge bit_clk) disable iff (!rst_n)
    pwr_n |=> (lane_oe == '1 && fclk_oe)); // R6
  AST_FLOAT_LOW: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (pwr_n && din_float) |=> (lane_q == '0 && lane_oe == '1)); // R7
  AST_FCLK_PERIOD: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (rise && fclk_oe && armed_q == 3'd4) |-> (gap_q == 8'(RATIO - 1))); // R8
endmodule

bind lane_serializer ser_checker #(.LANES(LANES), .RATIO(RATIO)) u_chk (
  .bit_clk   (bit_clk),
  .rst_n     (rst_bit_n),
  .pwr_n     (pwr_n),
  .din_float (din_float),
  .lane_q    (lane_q),
  .lane_oe   (lane_oe),
  .fclk_q    (fclk_q),
  .fclk_oe   (fclk_oe)
);

// File: tb/lane_serializer_tb.sv
module lane_serializer_tb;
  logic        bit_clk, word_clk, rst_n, pwr_n, edge_sel, din_float;
  logic [20:0] din;
  logic [2:0]  lane_q, lane_oe;
  logic        fclk_q, fclk_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit wclk_run = 1;
  bit tog = 0;
  logic [20:0] tog_a, tog_b;
  logic [20:0] hist [0:63];
  int n_hist = 0;

  lane_serializer u_dut (
    .bit_clk(bit_clk), .word_clk(word_clk), .rst_n(rst_n), .pwr_n(pwr_n),
    .edge_sel(edge_sel), .din_float(din_float), .din(din),
    .lane_q(lane_q), .lane_oe(lane_oe), .fclk_q(fclk_q), .fclk_oe(fclk_oe)
  );

  initial begin
    bit_clk = 0;
    forever #4 bit_clk = ~bit_clk;
  end

  initial begin
    word_clk = 0;
    #2;
    forever begin
      if (wclk_run) word_clk = 1;
      #28;
      if (wclk_run) word_clk = 0;
      #28;
    end
  end

  always @(posedge word_clk) if (tog) begin #10; din = tog_b; end
  always @(negedge word_clk) if (tog) begin #10; din = tog_a; end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic get_frame(output logic [20:0] w, output logic [6:0] p);
    logic prev;
    bit found = 0;
    w = '0; p = '0;
    @(negedge bit_clk); prev = fclk_q;
    for (int i = 0; i < 40 && !found; i++) begin
      @(negedge bit_clk);
      if (!prev && fclk_q) found = 1;
      prev = fclk_q;
    end
    if (!found) begin
      check("R3 marker", 0, 1);
    end else begin
      @(negedge bit_clk);
      for (int s = 0; s < 7; s++) begin
        @(negedge bit_clk);
        p[s] = fclk_q;
        for (int k = 0; k < 3; k++) w[7*k+s] = lane_q[k];
      end
    end
  endtask

  task automatic wait_words(input int n);
    repeat (n*7) @(negedge bit_clk);
  endtask

  task automatic t_reset;
    rst_n = 0; pwr_n = 1; edge_sel = 0; din_float = 0; din = '0;
    repeat (10) @(negedge bit_clk);
    check("R1 lane_oe in reset", 32'(lane_oe), 0);
    check("R1 fclk_oe in reset", 32'(fclk_oe), 0);
    rst_n = 1;
    wait_words(4);
  endtask

  task automatic t_mapping(input logic [20:0] v);
    logic [20:0] w; logic [6:0] p;
    din = v;
    wait_words(4);
    get_frame(w, p);
    check("R2 lane mapping", 32'(w), 32'(v));
    check("R3 clock pattern", 32'(p), 32'(7'b1100011));
  endtask

  task automatic t_edges;
    logic [20:0] w; logic [6:0] p;
    tog_a = 21'h0a5a5a; tog_b = 21'h15a5a5; din = tog_a;
    @(negedge bit_clk); tog = 1;
    edge_sel = 0;
    wait_words(5);
    get_frame(w, p);
    check("R4 rising capture", 32'(w), 32'(tog_a));
    edge_sel = 1;
    wait_words(5);
    get_frame(w, p);
    check("R5 falling capture", 32'(w), 32'(tog_b));
    tog = 0;
    wait_words(2);
    edge_sel = 0;
  endtask

  task automatic t_power;
    logic [20:0] w; logic [6:0] p;
    din = 21'h1c3a96;
    wait_words(4);
    @(negedge bit_clk); pwr_n = 0;
    repeat (2) @(negedge bit_clk);
    check("R6 lane_oe off", 32'(lane_oe), 0);
    check("R6 fclk_oe off", 32'(fclk_oe), 0);
    pwr_n = 1;
    repeat (2) @(negedge bit_clk);
    check("R6 enables back", 32'({fclk_oe, lane_oe}), 32'hf);
    get_frame(w, p);
    check("R6 data resumes", 32'(w), 32'(21'h1c3a96));
  endtask

  task automatic t_float;
    logic [20:0] w; logic [6:0] p;
    bit bad = 0;
    din = 21'h1fffff;
    wait_words(4);
    @(negedge bit_clk); din_float = 1;
    repeat (2) @(negedge bit_clk);
    for (int i = 0; i < 7; i++) begin
      if (lane_q !== 3'b000 || lane_oe !== 3'b111) bad = 1;
      @(negedge bit_clk);
    end
    check("R7 data lanes low", 32'(bad), 0);
    get_frame(w, p);
    check("R7 lanes low in frame", 32'(w), 0);
    check("R7 clock pattern kept", 32'(p), 32'(7'b1100011));
    din_float = 0;
    wait_words(2);
  endtask

  task automatic t_steady;
    logic [20:0] w; logic [6:0] p;
    logic prev;
    int gap;
    din = 21'h0f0f33;
    wait_words(4);
    wclk_run = 0;
    wait_words(3);
    din = 21'h10c0de;
    @(negedge bit_clk); prev = fclk_q;
    while (!( !prev && fclk_q)) begin prev = fclk_q; @(negedge bit_clk); end
    for (int r = 0; r < 3; r++) begin
      gap = 0;
      prev = fclk_q;
      do begin @(negedge bit_clk); gap++; if (!prev && fclk_q) break; prev = fclk_q; end
      while (gap < 40);
      check("R8 free-running period", 32'(gap), 7);
    end
    get_frame(w, p);
    check("R8 last word held", 32'(w), 32'(21'h0f0f33));
    wclk_run = 1;
    wait_words(4);
    get_frame(w, p);
    check("R8 capture after restart", 32'(w), 32'(21'h10c0de));
  endtask

  task automatic t_integrity;
    logic [31:0] v = 32'h1234567;
    n_hist = 1; hist[0] = din;
    fork
      begin
        for (int i = 0; i < 40; i++) begin
          repeat (3) @(negedge bit_clk);
          v = v * 32'd1103515245 + 32'd12345;
          din = v[30:10];
          hist[n_hist] = v[30:10];
          n_hist++;
        end
      end
      begin
        for (int f = 0; f < 5; f++) begin
          logic [20:0] w; logic [6:0] p;
          bit hit = 0;
          get_frame(w, p);
          for (int j = 0; j < n_hist; j++) if (hist[j] == w) hit = 1;
          check("R9 frame is one whole word", 32'(hit), 1);
        end
      end
    join
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_mapping(21'h000001);
    t_mapping(21'h155555);
    t_mapping(21'h1e0c81);
    t_edges();
    t_power();
    t_float();
    t_steady();
    t_integrity();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule